// File: doc/BRIEF.md
# Dual-Accept Instruction Queue with Branch Folding

This block sits between an instruction fetch unit and a single-issue dispatch stage. Each clock, fetch offers up to two instructions. Each one carries a branch flag and a conditional flag, and a branch also carries its target. Non-branch instructions are stored in a small in-order queue and leave it one per clock, oldest first. Branch instructions never enter the queue. They are folded out at the moment of acceptance and handed to a branch side port, so they cost no dispatch slot.

A configuration input selects the static prediction for conditional branches: predict taken or predict not taken. Unconditional branches are always predicted taken. When a folded branch is predicted taken, a one-cycle redirect pulse gives fetch the branch target. In that case the second instruction of the same fetched pair is on the wrong path and is consumed without being stored.

A mispredict flush clears the queue and the side port in the cycle it is asserted.

Top module: `insn_fold_queue`

## Requirements
- R1: After reset, the queue is empty (`disp_valid`=0), the side port is empty (`br_valid`=0), `redir_valid`=0, and `fetch_room`=2.
- R2: `fetch_room` reads 2 when two or more entries are free, 1 when exactly one entry is free, and 0 when the queue is full. The count of free entries is taken from the start of the cycle, so a dispatch in the same cycle does not add room.
- R3: `fetch_take[0]` is set when slot 0 is valid, room is at least 1, no flush is active, and the side port is free (or slot 0 is not a branch). `fetch_take[1]` is only ever set together with `fetch_take[0]`.
- R4: A branch (`fetch_br` bit set) is never stored and never appears on the dispatch port. It is loaded onto the side port in the cycle after it is accepted.
- R5: `br_taken` is 1 for an unconditional branch (`fetch_cond` bit 0). For a conditional branch it equals `pred_taken` as sampled at acceptance.
- R6: When slot 0 is a branch predicted taken and slot 1 is valid, slot 1 is consumed (`fetch_take[1]`=1) but is not stored.
- R7: In the cycle after a branch predicted taken is accepted, `redir_valid`=1 for one cycle, with `redir_pc` equal to that branch's target.
- R8: The side port holds its branch while `br_ready`=0. A new branch is accepted only when the port is empty or is being drained in that cycle.
- R9: Stored instructions dispatch in program order, one per clock where `disp_valid` and `disp_ready` are both high.
- R10: A flush drives `fetch_take` to 0. In the next cycle the queue and the side port are empty and `redir_valid`=0.
- R11: The queue never holds more than DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_taken | input | 1 | Static prediction for conditional branches (1 = predict taken) |
| flush | input | 1 | Mispredict flush |
| fetch_valid | input | 2 | Per-slot valid; slot 1 may only be valid if slot 0 is valid |
| fetch_br | input | 2 | Per-slot branch flag; at most one bit set |
| fetch_cond | input | 2 | Per-slot conditional-branch flag |
| fetch_insn | input | 2*IW | Instruction words; slot 0 in the low half |
| fetch_pc | input | 2*AW | Instruction addresses; slot 0 in the low half |
| fetch_tgt | input | 2*AW | Branch targets; slot 0 in the low half |
| fetch_room | output | 2 | Grant width: 0, 1 or 2 |
| fetch_take | output | 2 | Per-slot consume indication for this cycle |
| disp_valid | output | 1 | Head entry is valid |
| disp_ready | input | 1 | Dispatch stage takes the head entry |
| disp_insn | output | IW | Head instruction word |
| disp_pc | output | AW | Head instruction address |
| br_valid | output | 1 | Folded branch present on the side port |
| br_ready | input | 1 | Side port consumer takes the branch |
| br_pc | output | AW | Folded branch address |
| br_tgt | output | AW | Folded branch target |
| br_taken | output | 1 | Predicted direction of the folded branch |
| redir_valid | output | 1 | One-cycle fetch redirect pulse |
| redir_pc | output | AW | Redirect target |

## Verification
`fetch_room` and `fetch_take` respond within the same cycle: `fetch_room` follows the stored count, and `fetch_take` also follows the present inputs. Dispatch contents, the side-port branch and the redirect pulse appear one edge after the accept that caused them. A flush shows its effect on `fetch_take` at once and on the storage one edge later. The bench drives new inputs just after the falling edge and settles for a moment before comparing every output. It compares same-cycle results against a queue model evaluated on those inputs. It compares registered results against the model state advanced at the previous rising edge. This means every check lands in the cycle its result is due.

// File: rtl/fold_pkg.sv
package fold_pkg;
  typedef enum logic [1:0] {
    ROOM_NONE = 2'd0,
    ROOM_ONE  = 2'd1,
    ROOM_TWO  = 2'd2
  } room_t;
endpackage

// File: rtl/fq_accept.sv
module fq_accept
  import fold_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count,
  input  logic          flush,
  input  logic          pred_taken,
  input  logic          side_free,
  input  logic [1:0]    valid,
  input  logic [1:0]    br,
  input  logic [1:0]    cond,
  output room_t         room,
  output logic [1:0]    take,
  output logic          st0,
  output logic          st1,
  output logic          ld,
  output logic          ld_sel,
  output logic          ld_taken
);
  logic [CW-1:0] free_n;
  logic          tk0, t0, t1, ld0, ld1;

  always_comb begin
    free_n = CW'(DEPTH) - count;
    if (free_n >= CW'(2))      room = ROOM_TWO;
    else if (free_n == CW'(1)) room = ROOM_ONE;
    else                       room = ROOM_NONE;
    tk0 = br[0] && (!cond[0] || pred_taken);
    t0  = !flush && valid[0] && (room != ROOM_NONE) && (!br[0] || side_free);
    t1  = t0 && valid[1] && (tk0 || ((room == ROOM_TWO) && (!br[1] || side_free)));
    take = {t1, t0};
    st0 = t0 && !br[0];
    st1 = t1 && !br[1] && !tk0;
    ld0 = t0 && br[0];
    ld1 = t1 && br[1] && !tk0;
    ld  = ld0 || ld1;
    ld_sel = !ld0;
    ld_taken = ld_sel ? (!cond[1] || pred_taken) : (!cond[0] || pred_taken);
  end

  a_r3_pair_order: assert property (@(posedge clk) disable iff (rst) take[1] |-> take[0]);
  a_r2_no_grant_when_full: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(DEPTH)) |-> !take[0]);
  a_r10_flush_blocks: assert property (@(posedge clk) disable iff (rst) flush |-> take == 2'b00);
endmodule

// File: rtl/fq_store.sv
module fq_store #(
  parameter int DEPTH = 4,
  parameter int IW = 32,
  parameter int AW = 32,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH),
  localparam int EW = IW + AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          st0,
  input  logic          st1,
  input  logic [EW-1:0] d0,
  input  logic [EW-1:0] d1,
  input  logic          pop,
  output logic          head_valid,
  output logic [EW-1:0] head,
  output logic [CW-1:0] count
);
  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [1:0]    nw;
  logic          do_pop;
  logic [EW-1:0] first;

  assign nw     = {1'b0, st0} + {1'b0, st1};
  assign do_pop = pop && head_valid && !flush;
  assign first  = st0 ? d0 : d1;

  always_ff @(posedge clk) begin
    if (!flush && nw != 2'd0) mem[wp] <= first;
    if (!flush && nw == 2'd2) mem[wp + PW'(1)] <= d1;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      wp <= wp + PW'(nw);
      if (do_pop) rp <= rp + PW'(1);
      count <= count + CW'(nw) - CW'(do_pop);
    end
  end

  assign head_valid = (count != '0);
  assign head = mem[rp];

  a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst) count <= CW'(DEPTH));
  a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst) flush |=> count == '0);
  a_r9_single_pop: assert property (@(posedge clk) disable iff (rst)
    (!flush && nw == 2'd0 && do_pop) |=> count == $past(count) - CW'(1));
endmodule

// File: rtl/fq_branch.sv
module fq_branch #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          ld,
  input  logic [AW-1:0] ld_pc,
  input  logic [AW-1:0] ld_tgt,
  input  logic          ld_taken,
  input  logic          ready,
  output logic          side_free,
  output logic          bp_valid,
  output logic [AW-1:0] bp_pc,
  output logic [AW-1:0] bp_tgt,
  output logic          bp_taken,
  output logic          redir_valid,
  output logic [AW-1:0] redir_pc
);
  assign side_free = !bp_valid || ready;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      bp_valid <= 1'b0;
      redir_valid <= 1'b0;
    end else begin
      if (ld) bp_valid <= 1'b1;
      else if (ready) bp_valid <= 1'b0;
      redir_valid <= ld && ld_taken;
    end
    if (ld) begin
      bp_pc <= ld_pc;
      bp_tgt <= ld_tgt;
      bp_taken <= ld_taken;
      redir_pc <= ld_tgt;
    end
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (bp_valid && !ready && !flush) |=> (bp_valid && $stable(bp_pc) && $stable(bp_tgt)));
  a_r7_redirect_matches: assert property (@(posedge clk) disable iff (rst)
    redir_valid |-> (bp_valid && bp_taken && redir_pc == bp_tgt));
endmodule

// File: rtl/insn_fold_queue.sv
module insn_fold_queue
  import fold_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IW = 32,
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pred_taken,
  input  logic            flush,
  input  logic [1:0]      fetch_valid,
  input  logic [1:0]      fetch_br,
  input  logic [1:0]      fetch_cond,
  input  logic [2*IW-1:0] fetch_insn,
  input  logic [2*AW-1:0] fetch_pc,
  input  logic [2*AW-1:0] fetch_tgt,
  output logic [1:0]      fetch_room,
  output logic [1:0]      fetch_take,
  output logic            disp_valid,
  input  logic            disp_ready,
  output logic [IW-1:0]   disp_insn,
  output logic [AW-1:0]   disp_pc,
  output logic            br_valid,
  input  logic            br_ready,
  output logic [AW-1:0]   br_pc,
  output logic [AW-1:0]   br_tgt,
  output logic            br_taken,
  output logic            redir_valid,
  output logic [AW-1:0]   redir_pc
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = IW + AW;

  logic [CW-1:0] count;
  logic          side_free, st0, st1, ld, ld_sel, ld_taken;
  room_t         room;
  logic [EW-1:0] head;

  fq_accept #(.DEPTH(DEPTH)) u_acc (
    .clk(clk), .rst(rst), .count(count), .flush(flush), .pred_taken(pred_taken),
    .side_free(side_free), .valid(fetch_valid), .br(fetch_br), .cond(fetch_cond),
    .room(room), .take(fetch_take), .st0(st0), .st1(st1), .ld(ld), .ld_sel(ld_sel),
    .ld_taken(ld_taken)
  );

  assign fetch_room = room;

  fq_store #(.DEPTH(DEPTH), .IW(IW), .AW(AW)) u_store (
    .clk(clk), .rst(rst), .flush(flush), .st0(st0), .st1(st1),
    .d0({fetch_pc[AW-1:0], fetch_insn[IW-1:0]}),
    .d1({fetch_pc[2*AW-1:AW], fetch_insn[2*IW-1:IW]}),
    .pop(disp_ready), .head_valid(disp_valid), .head(head), .count(count)
  );

  assign disp_insn = head[IW-1:0];
  assign disp_pc   = head[EW-1:IW];

  fq_branch #(.AW(AW)) u_br (
    .clk(clk), .rst(rst), .flush(flush), .ld(ld),
    .ld_pc(ld_sel ? fetch_pc[2*AW-1:AW] : fetch_pc[AW-1:0]),
    .ld_tgt(ld_sel ? fetch_tgt[2*AW-1:AW] : fetch_tgt[AW-1:0]),
    .ld_taken(ld_taken), .ready(br_ready), .side_free(side_free),
    .bp_valid(br_valid), .bp_pc(br_pc), .bp_tgt(br_tgt), .bp_taken(br_taken),
    .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  a_r4_branch_not_stored: assert property (@(posedge clk) disable iff (rst)
    (fetch_take[0] && fetch_br[0] && !fetch_take[1] && !disp_ready) |=> $stable(count));
  a_r6_squash_slot1: assert property (@(posedge clk) disable iff (rst)
    (fetch_take[0] && fetch_br[0] && !fetch_cond[0] && !disp_ready) |=> $stable(count));
endmodule

// File: tb/insn_fold_queue_test.sv
module insn_fold_queue_test;
  localparam int DEPTH = 4;
  localparam int IW = 32;
  localparam int AW = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst, pred_taken, flush, disp_ready, br_ready;
  logic [1:0]      fetch_valid, fetch_br, fetch_cond, fetch_room, fetch_take;
  logic [2*IW-1:0] fetch_insn;
  logic [2*AW-1:0] fetch_pc, fetch_tgt;
  logic            disp_valid, br_valid, br_taken, redir_valid;
  logic [IW-1:0]   disp_insn;
  logic [AW-1:0]   disp_pc, br_pc, br_tgt, redir_pc;

  insn_fold_queue #(.DEPTH(DEPTH), .IW(IW), .AW(AW)) uut (.*);

  int checks = 0;
  int errors = 0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference model state
  logic [IW+AW-1:0] mq[$];
  bit        m_bv, m_btk, m_rv;
  logic [AW-1:0] m_bpc, m_btgt, m_rpc;
  logic [AW-1:0] pc_next;
  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic drive_random(int ready_pct, int flush_pct, int fetch_pct);
    logic [1:0] v, b, c;
    v = 2'b00; b = 2'b00; c = 2'b00;
    if ($urandom_range(99) < fetch_pct) begin
      v[0] = 1'b1;
      v[1] = ($urandom_range(3) != 0);
      case ($urandom_range(5))
        0: b = 2'b01;
        1: if (v[1]) b = 2'b10;
        default: b = 2'b00;
      endcase
      c = 2'($urandom_range(3));
    end
    fetch_valid = v; fetch_br = b; fetch_cond = c;
    fetch_insn = {32'($urandom), 32'($urandom)};
    fetch_pc = {pc_next + 32'd4, pc_next};
    fetch_tgt = {32'($urandom) & 32'hFFFC, 32'($urandom) & 32'hFFFC};
    disp_ready = ($urandom_range(99) < ready_pct);
    br_ready = ($urandom_range(99) < ready_pct);
    flush = ($urandom_range(99) < flush_pct);
    if ($urandom_range(15) == 0) pred_taken = ~pred_taken;
  endtask

  task automatic step_and_check();
    int free_n, room;
    bit side_free, tk0, t0, t1, st0, st1, ld0, ld1, ldt, popd;
    logic [IW+AW-1:0] e0, e1;
    #1;
    free_n = DEPTH - mq.size();
    room = free_n >= 2 ? 2 : free_n;
    side_free = !m_bv || br_ready;
    tk0 = fetch_br[0] && (!fetch_cond[0] || pred_taken);
    t0 = !flush && fetch_valid[0] && room != 0 && (!fetch_br[0] || side_free);
    t1 = t0 && fetch_valid[1] && (tk0 || (room == 2 && (!fetch_br[1] || side_free)));
    chk("R2 room", fetch_room, room);
    chk("R3 take0", fetch_take[0], t0);
    chk("R6/R3 take1", fetch_take[1], t1);
    chk("R9 disp_valid", disp_valid, mq.size() != 0);
    if (mq.size() != 0) begin
      chk("R9 disp_insn", disp_insn, mq[0][IW-1:0]);
      chk("R9 disp_pc", disp_pc, mq[0][IW+AW-1:IW]);
    end
    chk("R4 br_valid", br_valid, m_bv);
    if (m_bv) begin
      chk("R4 br_pc", br_pc, m_bpc);
      chk("R8 br_tgt", br_tgt, m_btgt);
      chk("R5 br_taken", br_taken, m_btk);
    end
    chk("R7 redir_valid", redir_valid, m_rv);
    if (m_rv) chk("R7 redir_pc", redir_pc, m_rpc);
    // advance model
    st0 = t0 && !fetch_br[0];
    st1 = t1 && !fetch_br[1] && !tk0;
    ld0 = t0 && fetch_br[0];
    ld1 = t1 && fetch_br[1] && !tk0;
    e0 = {fetch_pc[AW-1:0], fetch_insn[IW-1:0]};
    e1 = {fetch_pc[2*AW-1:AW], fetch_insn[2*IW-1:IW]};
    if (flush) begin
      mq.delete(); m_bv = 0; m_rv = 0;
    end else begin
      popd = disp_ready && mq.size() != 0;
      if (popd) void'(mq.pop_front());
      if (st0) mq.push_back(e0);
      if (st1) mq.push_back(e1);
      if (m_bv && br_ready) m_bv = 0;
      m_rv = 0;
      if (ld0 || ld1) begin
        ldt = ld0 ? (!fetch_cond[0] || pred_taken) : (!fetch_cond[1] || pred_taken);
        m_bv = 1; m_btk = ldt;
        m_bpc = ld0 ? fetch_pc[AW-1:0] : fetch_pc[2*AW-1:AW];
        m_btgt = ld0 ? fetch_tgt[AW-1:0] : fetch_tgt[2*AW-1:AW];
        m_rv = ldt; m_rpc = m_btgt;
      end
    end
    if (t1) pc_next = pc_next + 32'd8;
    else if (t0) pc_next = pc_next + 32'd4;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; pred_taken = 1'b0; flush = 1'b0; disp_ready = 1'b0; br_ready = 1'b0;
    fetch_valid = 2'b00; fetch_br = 2'b00; fetch_cond = 2'b00;
    fetch_insn = '0; fetch_pc = '0; fetch_tgt = '0;
    pc_next = 32'h1000;
    m_bv = 0; m_rv = 0; m_btk = 0; m_bpc = '0; m_btgt = '0; m_rpc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 disp_valid", disp_valid, 0);
    chk("R1 br_valid", br_valid, 0);
    chk("R1 redir_valid", redir_valid, 0);
    chk("R1 room", fetch_room, 2);
    // directed: taken unconditional branch in slot 0 squashes slot 1 (R6, R7)
    fetch_valid = 2'b11; fetch_br = 2'b01; fetch_cond = 2'b00;
    fetch_pc = {32'h1004, 32'h1000}; fetch_tgt = {32'h0, 32'h2000};
    fetch_insn = {32'hAAAA0001, 32'hBBBB0002};
    step_and_check();
    fetch_valid = 2'b00;
    chk("R6 slot1 not stored", disp_valid, 0);
    step_and_check();
    // fill with ready low, then drain slowly (R2, R8, R9, R11)
    for (int i = 0; i < 400; i++) begin
      drive_random(10, 0, 90);
      step_and_check();
    end
    // mixed traffic with flushes (R10) and prediction toggling (R5)
    for (int i = 0; i < 3000; i++) begin
      drive_random(60, 4, 80);
      step_and_check();
    end
    // fast drain
    for (int i = 0; i < 400; i++) begin
      drive_random(95, 1, 50);
      step_and_check();
    end
    // explicit flush check (R10)
    drive_random(0, 0, 100);
    step_and_check();
    flush = 1'b1; fetch_valid = 2'b11; fetch_br = 2'b00;
    step_and_check();
    flush = 1'b0; fetch_valid = 2'b00;
    #1;
    chk("R10 queue empty", disp_valid, 0);
    chk("R10 side empty", br_valid, 0);
    chk("R10 redirect cleared", redir_valid, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule